// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

A register-mapped event counting block holding two independent 40-bit counters and one shared control register. Software reaches all three through a register-number input and a 64-bit value split into a high and a low 32-bit word, in the style of a read/write model-specific-register instruction pair. Writes are taken on the clock edge. Reads are combinational from the register number.

Each clock the unit receives three inputs. The first is a vector of per-cycle event strobes, indexed by event code. The second is the current privilege level, 0 to 3. The third is a cycle qualifier that marks the clocks to be counted in cycle mode.

Each counter takes its event code, its two privilege enables and its counting mode from its own 16-bit half of the control register. It then increments by one on every qualifying clock. Generating the strobes is left to the surrounding logic.

Top module: `perf_counter_unit`

## Requirements
- R1: Register number 11h selects the control register, 12h selects counter 0 and 13h selects counter 1. A write to any other number changes nothing, and a read of any other number returns zero.
- R2: Control bits 15:0 configure counter 0 and bits 31:16 configure counter 1, with the same layout in each half. Within a half, bits 5:0 are the event code, bit 6 enables counting at privilege levels 0 to 2, bit 7 enables counting at level 3, and bit 8 selects the method (1 = cycles, 0 = events).
- R3: The reserved control bits read back as zero. These are bits 15:9 and 31:25 and the whole of bits 63:32, whatever was written to them.
- R4: In event mode a counter increments by one on a clock where its privilege condition holds and the strobe at index equal to its event code is 1.
- R5: In cycle mode a counter increments by one on every clock where its privilege condition holds and the cycle qualifier is 1. The event strobes have no effect in this mode.
- R6: At privilege level 3 only bit 7 of the half can allow counting. At levels 0, 1 and 2 only bit 6 can. When the relevant bit is 0 the counter holds.
- R7: Event codes 20h and 21h, and any code at or above the strobe vector width (2Ah with defaults), never count in event mode.
- R8: A counter wraps from all ones to zero.
- R9: A counter write loads bits 39:0 of {high, low} and ignores bits 63:40. A counter read returns zero in bits 63:40.
- R10: A write to a counter on the same clock as an increment loads the written value, and the increment is lost.
- R11: A synchronous reset clears the control register and both counters.
- R12: The two counters count independently, each from its own half of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_num | input | 32 | Register number for read and write |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| wr_hi | input | 32 | Write value, bits 63:32 |
| wr_lo | input | 32 | Write value, bits 31:0 |
| rd_hi | output | 32 | Read value of register reg_num, bits 63:32 |
| rd_lo | output | 32 | Read value of register reg_num, bits 31:0 |
| event_vec | input | 42 | Per-cycle event strobes, bit n = event code n |
| priv_level | input | 2 | Current privilege level 0 to 3 |
| cycle_tick | input | 1 | Cycle qualifier used in cycle mode |

## Verification
The bench builds the block with its default parameters: 40-bit counters, a 42-entry strobe vector, and the adder split at bit 20. With a 42-entry vector, the codes from 2Ah to 3Fh have no strobe, so the out-of-range side of R7 can be reached. Counters are preloaded to within a few counts of all ones, so the 40-bit wrap and the carry across the split adder both occur in a short run. Control writes set every reserved bit to one, which exposes any leak into readback.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   localparam int HALF_W = 16;   // control bits per counter
   localparam int WORD_W = 32;
   localparam int REG_W  = 64;
   localparam int CODE_W = 6;
   localparam int SEL_W  = 9;    // live bits per half: code, two ring enables, method

   localparam logic [CODE_W-1:0] HOLE_LO = 6'h20;
   localparam logic [CODE_W-1:0] HOLE_HI = 6'h21;

   // Packed so that bit positions equal the control layout of one half.
   typedef struct packed {
      logic              cycle_mode;   // bit 8
      logic              ring3_en;     // bit 7
      logic              ring012_en;   // bit 6
      logic [CODE_W-1:0] code;         // bits 5:0
   } sel_t;

   function automatic logic code_live(input logic [CODE_W-1:0] c, input int n_ev);
      return (int'(c) < n_ev) && (c != HOLE_LO) && (c != HOLE_HI);
   endfunction

   function automatic logic [REG_W-1:0] sel_mask(input int n_cnt);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < n_cnt; i++) m[i*HALF_W +: SEL_W] = '1;
      return m;
   endfunction

endpackage

// File: rtl/pmc_sel_reg.sv
module pmc_sel_reg
   import pmc_pkg::*;
#(
   parameter int NUM_CNT = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr,
   input  logic [REG_W-1:0]       wr_data,
   output sel_t [NUM_CNT-1:0]     sel,
   output logic [REG_W-1:0]       rb
);

   localparam logic [REG_W-1:0] LIVE_MASK = sel_mask(NUM_CNT);

   sel_t sel_q [NUM_CNT];
   logic unused_wr_bits;

   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_CNT; i++) sel_q[i] <= '0;
      end else if (wr) begin
         for (int i = 0; i < NUM_CNT; i++) sel_q[i] <= sel_t'(wr_data[i*HALF_W +: SEL_W]);
      end
   end

   always_comb begin
      rb = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         rb[i*HALF_W +: SEL_W] = sel_q[i];
         sel[i]                = sel_q[i];
      end
   end

   // R2 / R3: a control write reads back as the written live bits only
   a_r3_ctrl_readback: assert property (@(posedge clk) disable iff (rst)
      wr |=> rb == ($past(wr_data) & LIVE_MASK));

   // R11: reset empties the control register
   a_r11_ctrl_reset: assert property (@(posedge clk)
      rst |=> rb == '0);

endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
   import pmc_pkg::*;
#(
   parameter int NUM_EVENTS = 42
) (
   input  logic                   clk,
   input  logic                   rst,
   input  sel_t                   sel,
   input  logic [NUM_EVENTS-1:0]  ev,
   input  logic [1:0]             priv,
   input  logic                   tick,
   output logic                   inc
);

   logic [63:0] ev_pad;
   logic        ring_ok;
   logic        evt_hit;

   assign ev_pad  = 64'(ev);
   assign ring_ok = (priv == 2'd3) ? sel.ring3_en : sel.ring012_en;
   assign evt_hit = code_live(sel.code, NUM_EVENTS) && ev_pad[sel.code];
   assign inc     = ring_ok && (sel.cycle_mode ? tick : evt_hit);

   // R7: holes and codes beyond the strobe vector never count as events
   a_r7_dead_code_silent: assert property (@(posedge clk) disable iff (rst)
      (!sel.cycle_mode && (sel.code == HOLE_LO || sel.code == HOLE_HI ||
                           int'(sel.code) >= NUM_EVENTS)) |-> !inc);

   // R6: the enable for the current ring gates every increment
   a_r6_ring_blocks: assert property (@(posedge clk) disable iff (rst)
      ((priv == 2'd3 && !sel.ring3_en) || (priv != 2'd3 && !sel.ring012_en)) |-> !inc);

   // R5: in cycle mode without a tick nothing counts
   a_r5_cycle_needs_tick: assert property (@(posedge clk) disable iff (rst)
      (sel.cycle_mode && !tick) |-> !inc);

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
   parameter int CNT_W = 40,
   parameter int LO_W  = 20    // 0 or >= CNT_W selects a single flat adder
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             inc,
   output logic [CNT_W-1:0] q
);

   logic [CNT_W-1:0] q_plus;

   generate
      if (LO_W > 0 && LO_W < CNT_W) begin : g_split
         localparam int HI_W = CNT_W - LO_W;
         logic lo_full;
         assign lo_full = &q[LO_W-1:0];
         assign q_plus  = {q[CNT_W-1:LO_W] + HI_W'(lo_full), q[LO_W-1:0] + LO_W'(1)};
      end else begin : g_flat
         assign q_plus = q + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= load_val;
      else if (inc)  q <= q_plus;
   end

   // R10: a load beats a same-cycle increment
   a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
      load |=> q == $past(load_val));

   // R4 / R8: an increment adds exactly one, modulo the width
   a_r8_step_wraps: assert property (@(posedge clk) disable iff (rst)
      (!load && inc) |=> q == $past(q) + CNT_W'(1));

   // R6: no load and no increment means the value holds
   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      (!load && !inc) |=> $stable(q));

   // R11: reset clears the count
   a_r11_cnt_reset: assert property (@(posedge clk)
      rst |=> q == '0);

endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
   import pmc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 40,
   parameter int NUM_EVENTS = 42,
   parameter int NUM_CNT    = 2,
   parameter int SEL_NUM    = 'h11,
   parameter int ADDER_LO_W = 20
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [ADDR_W-1:0]     reg_num,
   input  logic                  wr_en,
   input  logic [WORD_W-1:0]     wr_hi,
   input  logic [WORD_W-1:0]     wr_lo,
   output logic [WORD_W-1:0]     rd_hi,
   output logic [WORD_W-1:0]     rd_lo,
   input  logic [NUM_EVENTS-1:0] event_vec,
   input  logic [1:0]            priv_level,
   input  logic                  cycle_tick
);

   localparam logic [ADDR_W-1:0] SEL_ADDR  = ADDR_W'(SEL_NUM);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(SEL_NUM + NUM_CNT);

   // elaboration-time parameter checks
   generate
      if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt_w
         $error("CNT_W must lie in 2..64");
      end
      if (NUM_EVENTS < 1 || NUM_EVENTS > (1 << CODE_W)) begin : g_bad_events
         $error("NUM_EVENTS must lie in 1..64");
      end
      if (NUM_CNT < 1 || NUM_CNT * HALF_W > WORD_W) begin : g_bad_num_cnt
         $error("NUM_CNT halves must fit in the low control word");
      end
   endgenerate

   logic [REG_W-1:0]   wr_data;
   logic [REG_W-1:0]   rd_data;
   logic [REG_W-1:0]   sel_rb;
   sel_t [NUM_CNT-1:0] sel;
   logic [CNT_W-1:0]   cnt_q [NUM_CNT];
   logic               addr_hit;
   logic               cnt_hit;

   assign wr_data  = {wr_hi, wr_lo};
   assign addr_hit = (reg_num >= SEL_ADDR) && (reg_num <= LAST_ADDR);
   assign cnt_hit  = (reg_num > SEL_ADDR) && (reg_num <= LAST_ADDR);

   pmc_sel_reg #(.NUM_CNT(NUM_CNT)) u_sel (
      .clk     (clk),
      .rst     (rst),
      .wr      (wr_en && reg_num == SEL_ADDR),
      .wr_data (wr_data),
      .sel     (sel),
      .rb      (sel_rb)
   );

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
         logic inc;
         logic load;

         assign load = wr_en && (reg_num == ADDR_W'(SEL_NUM + 1 + i));

         pmc_gate #(.NUM_EVENTS(NUM_EVENTS)) u_gate (
            .clk  (clk),
            .rst  (rst),
            .sel  (sel[i]),
            .ev   (event_vec),
            .priv (priv_level),
            .tick (cycle_tick),
            .inc  (inc)
         );

         pmc_counter #(.CNT_W(CNT_W), .LO_W(ADDER_LO_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .load_val (wr_data[CNT_W-1:0]),
            .inc      (inc),
            .q        (cnt_q[i])
         );
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (reg_num == SEL_ADDR) rd_data = sel_rb;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (reg_num == ADDR_W'(SEL_NUM + 1 + i)) rd_data = REG_W'(cnt_q[i]);
      end
   end

   assign rd_hi = rd_data[REG_W-1:WORD_W];
   assign rd_lo = rd_data[WORD_W-1:0];

   // R1: numbers outside the map read as zero
   a_r1_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
      !addr_hit |-> {rd_hi, rd_lo} == '0);

   // R1: a stray write leaves the control register untouched
   a_r1_stray_write_keeps_sel: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !addr_hit) |=> $stable(sel_rb));

   // R9: counter reads carry zeros above the counter width
   a_r9_counter_top_zero: assert property (@(posedge clk) disable iff (rst)
      cnt_hit |-> ({rd_hi, rd_lo} >> CNT_W) == '0);

endmodule

// File: tb/tb_perf_counter_unit.sv
`timescale 1ns/1ps
module tb_perf_counter_unit;

   localparam int NEV = 42;
   localparam int CW  = 40;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [31:0]    reg_num = '0;
   logic           wr_en = 1'b0;
   logic [31:0]    wr_hi = '0;
   logic [31:0]    wr_lo = '0;
   logic [NEV-1:0] ev = '0;
   logic [1:0]     priv = '0;
   logic           tick = 1'b0;
   logic [31:0]    rd_hi;
   logic [31:0]    rd_lo;

   always #2.5 clk = ~clk;

   perf_counter_unit dut (
      .clk(clk), .rst(rst), .reg_num(reg_num), .wr_en(wr_en),
      .wr_hi(wr_hi), .wr_lo(wr_lo), .rd_hi(rd_hi), .rd_lo(rd_lo),
      .event_vec(ev), .priv_level(priv), .cycle_tick(tick)
   );

   // behavioural reference state
   logic [63:0]   m_ctrl = '0;
   logic [CW-1:0] m_cnt [2];
   int            checks = 0;
   int            errors = 0;
   bit            chk_en = 0;
   bit            done = 0;
   string         tag = "R11";

   function automatic logic [63:0] m_read(input logic [31:0] n);
      case (n)
         32'h11:  return m_ctrl;
         32'h12:  return {24'h0, m_cnt[0]};
         32'h13:  return {24'h0, m_cnt[1]};
         default: return 64'h0;
      endcase
   endfunction

   task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s reg=%0h actual=%h expected=%h", t, reg_num, act, exp);
      end
   endtask

   // one clock: compare the read port, predict the next state, advance
   task automatic step();
      logic [63:0]   n_ctrl;
      logic [CW-1:0] n_cnt [2];
      logic [15:0]   half;
      int            code;
      bit            en, ev_ok;
      #1;
      if (chk_en) check(tag, {rd_hi, rd_lo}, m_read(reg_num));
      n_ctrl = m_ctrl;
      n_cnt[0] = m_cnt[0];
      n_cnt[1] = m_cnt[1];
      if (rst) begin
         n_ctrl = '0;
         n_cnt[0] = '0;
         n_cnt[1] = '0;
      end else begin
         for (int i = 0; i < 2; i++) begin
            half  = m_ctrl[16*i +: 16];
            code  = int'(half[5:0]);
            en    = (priv == 2'd3) ? half[7] : half[6];
            ev_ok = (code < NEV) && (code != 32) && (code != 33) && ev[code];
            if (en && (half[8] ? tick : ev_ok)) n_cnt[i] = m_cnt[i] + 1'b1;
            if (wr_en && reg_num == 32'h12 + i) n_cnt[i] = {wr_hi[7:0], wr_lo};
         end
         if (wr_en && reg_num == 32'h11) n_ctrl = {wr_hi, wr_lo} & 64'h0000_0000_01FF_01FF;
      end
      @(posedge clk);
      m_ctrl = n_ctrl;
      m_cnt[0] = n_cnt[0];
      m_cnt[1] = n_cnt[1];
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] n, input logic [31:0] hi, input logic [31:0] lo);
      wr_en = 1'b1; reg_num = n; wr_hi = hi; wr_lo = lo;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [31:0] n);
      reg_num = n;
      step();
   endtask

   task automatic run(input int n, input bit rnd_ev, input bit rnd_tick);
      for (int k = 0; k < n; k++) begin
         if (rnd_ev) ev = NEV'({$urandom(), $urandom()});
         if (rnd_tick) tick = 1'($urandom());
         priv    = 2'($urandom());
         reg_num = 32'h11 + ($urandom() % 3);
         step();
      end
   endtask

   initial begin
      m_cnt[0] = '0;
      m_cnt[1] = '0;
      @(negedge clk);
      // R11: reset state
      rst = 1'b1;
      step();
      step();
      chk_en = 1;
      tag = "R11";
      rd(32'h11); rd(32'h12); rd(32'h13);
      rst = 1'b0;

      // R3: every reserved bit written as one must read back zero
      tag = "R3";
      wr(32'h11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      rd(32'h11);

      // R2: half layout, counter 0 on code 12h, counter 1 on code 16h, both rings
      tag = "R2";
      wr(32'h11, 32'h0, 32'h00D6_00D2);
      ev = '0; ev[6'h12] = 1'b1;
      rd(32'h12); rd(32'h12); rd(32'h13);
      ev = '0; ev[6'h16] = 1'b1;
      rd(32'h13); rd(32'h13); rd(32'h12);

      // R1: stray writes and reads
      tag = "R1";
      wr(32'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      wr(32'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      wr(32'h0,  32'hFFFF_FFFF, 32'hFFFF_FFFF);
      rd(32'h10); rd(32'h14); rd(32'hFFFF_FFFF);
      rd(32'h11); rd(32'h12); rd(32'h13);

      // R4: event mode with random strobes
      tag = "R4";
      run(60, 1, 1);

      // R5: cycle mode, strobes and tick random
      tag = "R5";
      wr(32'h11, 32'h0, 32'h01C0_01C5);
      run(60, 1, 1);
      tick = 1'b0; ev = '1;
      run(6, 0, 0);

      // R6: counter 0 only at ring 3, counter 1 only at rings 0-2
      tag = "R6";
      wr(32'h11, 32'h0, 32'h0140_0180);
      tick = 1'b1;
      run(40, 1, 0);

      // R7: undefined and out-of-range codes with all strobes high
      tag = "R7";
      ev = '1;
      wr(32'h11, 32'h0, 32'h00E1_00E0);
      run(8, 0, 0);
      wr(32'h11, 32'h0, 32'h00FF_00EA);
      run(8, 0, 0);

      // R8: wrap from all ones, crossing the adder split as well
      tag = "R8";
      wr(32'h11, 32'h0, 32'h01C0_01C0);
      tick = 1'b1; priv = 2'd0;
      wr(32'h12, 32'h0000_00FF, 32'hFFFF_FFFD);
      wr(32'h13, 32'h0, 32'h000F_FFFE);
      for (int k = 0; k < 5; k++) begin
         reg_num = 32'h12; step();
      end
      rd(32'h13); rd(32'h13);

      // R9: upper write bits dropped, upper read bits zero
      tag = "R9";
      tick = 1'b0;
      wr(32'h12, 32'hFFFF_FF12, 32'h1234_5678);
      rd(32'h12);
      wr(32'h13, 32'hABCD_EF00, 32'h0);
      rd(32'h13);

      // R10: write beats same-cycle increment
      tag = "R10";
      tick = 1'b1; priv = 2'd3;
      wr(32'h13, 32'h0, 32'h5);
      wr(32'h13, 32'h0, 32'h9);
      rd(32'h13);

      // R12: long random mixture with random writes
      tag = "R12";
      for (int k = 0; k < 3000; k++) begin
         ev   = NEV'({$urandom(), $urandom()});
         tick = 1'($urandom());
         priv = 2'($urandom());
         if (($urandom() % 8) == 0) begin
            wr(32'h10 + ($urandom() % 5), $urandom(), $urandom());
         end else begin
            reg_num = 32'h10 + ($urandom() % 5);
            step();
         end
      end

      // R11: reset in the middle of activity
      tag = "R11";
      rst = 1'b1;
      step();
      rst = 1'b0;
      rd(32'h11); rd(32'h12); rd(32'h13);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule